// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is a behavioural controller for a small NOR-style flash array. It takes two-step command sequences on a simple write bus and runs one of two internally timed operations on a single block: erasing it, which sets every bit to one, or scanning it to see whether it is blank. A status byte reports progress and errors. Each block has a lock input, and a supply-valid input gates erasure.

Reads are combinational on the address. In array mode a read returns the addressed word. In status mode a read of any address returns the status byte, zero-extended to the word width. The array comes out of reset with every word at `INIT_WORD` (all zeros by default), so a block is blank only after it has been erased.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in array mode, every word reads `INIT_WORD` (0x0000), no error bit is set, and the ready bit (status bit 7) is 1.
- R2: Writing 0x20 to an address in block B, then 0xD0 to an address in the same block B, with `vpp_ok_i` high and `lock_i[B]` low, starts an erase. Status bit 7 then reads 0 for exactly `ERASE_CYCLES` cycles after the confirm edge. At the end, every word of block B reads all ones and the other blocks are unchanged.
- R3: After any setup or confirm write, a read of any address returns the status byte in bits 7:0, with the upper bits zero. Status mode persists until 0xFF is written in idle, which returns reads to array mode. Unknown codes written in idle are ignored.
- R4: Status bit 0 is 1 only while an erase runs and `addr_i` lies in the block being erased.
- R5: A valid erase confirm with `vpp_ok_i` low erases nothing and sets status bit 3. The supply check has priority over the lock check.
- R6: A valid erase confirm to a block whose `lock_i` bit is 1, with the supply valid, erases nothing and sets status bit 1.
- R7: If the write after a setup is not the matching confirm code, or goes to a different block, the sequence is abandoned, no operation starts, and status bits 4 and 5 are set.
- R8: Writing 0xBC then 0xCB to the same block starts a blank check. Status bit 7 reads 0 for `BLOCK_WORDS` cycles. At the end, status bit 5 is set if any word in the block is not all ones. The array is not modified.
- R9: Any write made while an erase or a blank check is running is ignored, and the operation still completes.
- R10: Status bits 5, 4, 3 and 1 stay set until 0x50 is written in idle. That write clears them and leaves the read mode unchanged.
- R11: `standby_o` is 1 exactly when `ce_i` is low and no operation is running. An erase that is under way continues to completion after `ce_i` falls.
- R12: A write with `ce_i` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Address: block index in the upper bits, word index in the lower bits |
| wdata_i | input | 8 | Command byte |
| vpp_ok_i | input | 1 | Erase supply within range |
| lock_i | input | NUM_BLOCKS | Lock bit for each block; bit b locks block b |
| rdata_o | output | WORD_W | Array word or status byte |
| standby_o | output | 1 | Device idle with chip enable deasserted |

## Verification
The assertions check the following on every cycle:
- standby is only reported when the chip is disabled and ready;
- a running operation always has the timer active;
- an erase cannot be cut short by bus traffic;
- the fail bit is sticky;
- the erase-in-progress bit is only seen during an erase;
- any wrong write after an erase setup raises the sequence error.

Only the bench's scenarios can show the rest:
- the exact length of the busy window;
- that the array really reads all ones afterwards;
- the outcome of a blank check on blank and non-blank blocks;
- the priority of the supply check over the lock check;
- the persistence of status mode across the clear command.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERS_SETUP,
    ST_BC_SETUP,
    ST_ERASING,
    ST_BLANKCHK
  } seq_state_e;

  localparam logic [7:0] CMD_ERS_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERS_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_BC_SETUP    = 8'hBC;
  localparam logic [7:0] CMD_BC_CONFIRM  = 8'hCB;
  localparam logic [7:0] CMD_CLR_SR      = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

  localparam int SR_READY   = 7;
  localparam int SR_FAIL    = 5;
  localparam int SR_SEQ     = 4;
  localparam int SR_VPP     = 3;
  localparam int SR_LOCK    = 1;
  localparam int SR_ERASING = 0;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NB = 4,
  parameter int NW = 8,
  parameter int WW = 16,
  parameter logic [WW-1:0] INIT_WORD = '0,
  localparam int BW = $clog2(NB),
  localparam int AW = $clog2(NB) + $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic [BW-1:0] erase_blk_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_data_o,
  input  logic [AW-1:0] scan_addr_i,
  output logic [WW-1:0] scan_data_o
);
  logic [WW-1:0] words [NB*NW];

  for (genvar i = 0; i < NB*NW; i++) begin : g_word
    localparam logic [BW-1:0] WBLK = BW'(i / NW);
    logic [WW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= INIT_WORD;
      else if (erase_i && erase_blk_i == WBLK) q <= '1;
    end
    assign words[i] = q;
  end

  assign rd_data_o   = words[rd_addr_i];
  assign scan_data_o = words[scan_addr_i];
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] limit_i,
  output logic          run_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      limit_q <= limit_i;
    end else if (run_q) begin
      if (last_o) run_q <= 1'b0;
      else        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last_o = run_q && (cnt_q == limit_q - CW'(1));
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int NB = 4,
  parameter int NW = 8,
  parameter int WW = 16,
  parameter int ERASE_CYCLES = 20,
  parameter int CW = 5,
  localparam int BW = $clog2(NB),
  localparam int AW = $clog2(NB) + $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          vpp_ok_i,
  input  logic [NB-1:0] lock_i,
  input  logic          timer_last_i,
  input  logic [WW-1:0] scan_data_i,
  output logic          timer_start_o,
  output logic [CW-1:0] timer_limit_o,
  output logic          erase_o,
  output logic [BW-1:0] op_blk_o,
  output seq_state_e    state_o,
  output logic [7:0]    sr_o,
  output logic          stat_mode_o
);
  seq_state_e    state_q;
  logic [BW-1:0] blk_q;
  logic          stat_q, dirty_q;
  logic          e_fail_q, e_seq_q, e_vpp_q, e_lock_q;

  logic          wr, same_blk, ers_ok, bc_ok, go_erase, go_bc, word_dirty;
  logic [BW-1:0] addr_blk;

  assign wr         = ce_i && we_i;
  assign addr_blk   = addr_i[AW-1 -: BW];
  assign same_blk   = addr_blk == blk_q;
  assign ers_ok     = wdata_i == CMD_ERS_CONFIRM && same_blk;
  assign bc_ok      = wdata_i == CMD_BC_CONFIRM && same_blk;
  assign go_erase   = wr && state_q == ST_ERS_SETUP && ers_ok && vpp_ok_i && !lock_i[blk_q];
  assign go_bc      = wr && state_q == ST_BC_SETUP && bc_ok;
  assign word_dirty = scan_data_i != '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      stat_q   <= 1'b0;
      dirty_q  <= 1'b0;
      e_fail_q <= 1'b0;
      e_seq_q  <= 1'b0;
      e_vpp_q  <= 1'b0;
      e_lock_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr) begin
          unique case (wdata_i)
            CMD_ERS_SETUP: begin state_q <= ST_ERS_SETUP; blk_q <= addr_blk; stat_q <= 1'b1; end
            CMD_BC_SETUP:  begin state_q <= ST_BC_SETUP;  blk_q <= addr_blk; stat_q <= 1'b1; end
            CMD_CLR_SR: begin
              e_fail_q <= 1'b0; e_seq_q <= 1'b0; e_vpp_q <= 1'b0; e_lock_q <= 1'b0;
            end
            CMD_RD_ARRAY: stat_q <= 1'b0;
            default: ;
          endcase
        end
        ST_ERS_SETUP: if (wr) begin
          state_q <= ST_IDLE;
          if (!ers_ok) begin
            e_seq_q <= 1'b1; e_fail_q <= 1'b1;
          end else if (!vpp_ok_i) e_vpp_q <= 1'b1;
          else if (lock_i[blk_q]) e_lock_q <= 1'b1;
          else state_q <= ST_ERASING;
        end
        ST_BC_SETUP: if (wr) begin
          if (bc_ok) begin
            state_q <= ST_BLANKCHK;
            dirty_q <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            e_seq_q <= 1'b1; e_fail_q <= 1'b1;
          end
        end
        ST_ERASING: if (timer_last_i) state_q <= ST_IDLE;
        ST_BLANKCHK: begin
          if (word_dirty) dirty_q <= 1'b1;
          if (timer_last_i) begin
            state_q <= ST_IDLE;
            if (dirty_q || word_dirty) e_fail_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy          = state_q == ST_ERASING || state_q == ST_BLANKCHK;
  assign timer_start_o = go_erase || go_bc;
  assign timer_limit_o = go_erase ? CW'(ERASE_CYCLES) : CW'(NW);
  assign erase_o       = state_q == ST_ERASING && timer_last_i;
  assign op_blk_o      = blk_q;
  assign state_o       = state_q;
  assign stat_mode_o   = stat_q;
  assign sr_o = {!busy, 1'b0, e_fail_q, e_seq_q, e_vpp_q, 1'b0, e_lock_q,
                 state_q == ST_ERASING && same_blk};
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_WORDS  = 8,
  parameter int WORD_W       = 16,
  parameter int ERASE_CYCLES = 20,
  parameter logic [WORD_W-1:0] INIT_WORD = '0,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int IDX_W  = $clog2(BLOCK_WORDS),
  localparam int ADDR_W = BLK_W + IDX_W,
  localparam int CNT_W  = $clog2((ERASE_CYCLES > BLOCK_WORDS ? ERASE_CYCLES : BLOCK_WORDS) + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  vpp_ok_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  standby_o
);
  seq_state_e        state_w;
  logic [7:0]        sr_w;
  logic              stat_mode_w, timer_run_w, timer_last_w, timer_start_w, erase_w;
  logic [CNT_W-1:0]  timer_limit_w, timer_cnt_w;
  logic [BLK_W-1:0]  op_blk_w;
  logic [WORD_W-1:0] arr_data_w, scan_data_w;

  flash_cmd_fsm #(
    .NB(NUM_BLOCKS), .NW(BLOCK_WORDS), .WW(WORD_W),
    .ERASE_CYCLES(ERASE_CYCLES), .CW(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .ce_i, .we_i, .addr_i, .wdata_i, .vpp_ok_i, .lock_i,
    .timer_last_i  (timer_last_w),
    .scan_data_i   (scan_data_w),
    .timer_start_o (timer_start_w),
    .timer_limit_o (timer_limit_w),
    .erase_o       (erase_w),
    .op_blk_o      (op_blk_w),
    .state_o       (state_w),
    .sr_o          (sr_w),
    .stat_mode_o   (stat_mode_w)
  );

  flash_busy_timer #(.CW(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i (timer_start_w),
    .limit_i (timer_limit_w),
    .run_o   (timer_run_w),
    .cnt_o   (timer_cnt_w),
    .last_o  (timer_last_w)
  );

  flash_array #(
    .NB(NUM_BLOCKS), .NW(BLOCK_WORDS), .WW(WORD_W), .INIT_WORD(INIT_WORD)
  ) u_array (
    .clk_i, .rst_ni,
    .erase_i     (erase_w),
    .erase_blk_i (op_blk_w),
    .rd_addr_i   (addr_i),
    .rd_data_o   (arr_data_w),
    .scan_addr_i ({op_blk_w, timer_cnt_w[IDX_W-1:0]}),
    .scan_data_o (scan_data_w)
  );

  assign rdata_o   = stat_mode_w ? WORD_W'(sr_w) : arr_data_w;
  assign standby_o = !ce_i && sr_w[SR_READY];
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic       standby_o,
  input seq_state_e state_w,
  input logic [7:0] sr_w,
  input logic       timer_run_w,
  input logic       timer_last_w
);
  // R11
  standby_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (!ce_i && sr_w[SR_READY]));

  // R2
  busy_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_ERASING || state_w == ST_BLANKCHK) |-> timer_run_w);

  // R9
  erase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_ERASING && !timer_last_w) |=> state_w == ST_ERASING);

  // R10
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_w[SR_FAIL] && !(state_w == ST_IDLE && ce_i && we_i && wdata_i == CMD_CLR_SR))
    |=> sr_w[SR_FAIL]);

  // R4
  erasing_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_w[SR_ERASING] |-> (state_w == ST_ERASING && !sr_w[SR_READY]));

  // R7
  seq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_ERS_SETUP && ce_i && we_i && wdata_i != CMD_ERS_CONFIRM)
    |=> (sr_w[SR_SEQ] && sr_w[SR_FAIL]));
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .we_i(we_i), .wdata_i(wdata_i),
  .standby_o(standby_o), .state_w(state_w), .sr_w(sr_w),
  .timer_run_w(timer_run_w), .timer_last_w(timer_last_w)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int NB = 4, NW = 8, WW = 16, EC = 20;
  localparam int AW = $clog2(NB) + $clog2(NW);
  localparam logic [WW-1:0] ONES = '1;

  logic clk = 0, rst_n = 0, ce = 0, we = 0, vpp = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [NB-1:0] lock = '0;
  logic [WW-1:0] rdata;
  logic standby;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  flash_erase_seq #(.NUM_BLOCKS(NB), .BLOCK_WORDS(NW), .WORD_W(WW), .ERASE_CYCLES(EC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .vpp_ok_i(vpp), .lock_i(lock), .rdata_o(rdata), .standby_o(standby));

  // reference model
  int m_st, m_blk, m_cnt;
  bit m_stat, m_dirty, e5, e4, e3, e1;
  int mem [NB][NW];

  task automatic m_reset();
    m_st = 0; m_blk = 0; m_cnt = 0; m_stat = 0; m_dirty = 0;
    e5 = 0; e4 = 0; e3 = 0; e1 = 0;
    for (int b = 0; b < NB; b++) for (int w = 0; w < NW; w++) mem[b][w] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int b; bit wr;
      b = int'(addr) / NW; wr = ce && we;
      case (m_st)
        0: if (wr) begin
          if (wdata == 8'h20) begin m_st = 1; m_blk = b; m_stat = 1; end
          else if (wdata == 8'hBC) begin m_st = 2; m_blk = b; m_stat = 1; end
          else if (wdata == 8'h50) begin e5 = 0; e4 = 0; e3 = 0; e1 = 0; end
          else if (wdata == 8'hFF) m_stat = 0;
        end
        1: if (wr) begin
          m_st = 0;
          if (wdata == 8'hD0 && b == m_blk) begin
            if (!vpp) e3 = 1;
            else if (lock[m_blk]) e1 = 1;
            else begin m_st = 3; m_cnt = 0; end
          end else begin e4 = 1; e5 = 1; end
        end
        2: if (wr) begin
          if (wdata == 8'hCB && b == m_blk) begin m_st = 4; m_cnt = 0; m_dirty = 0; end
          else begin m_st = 0; e4 = 1; e5 = 1; end
        end
        3: if (m_cnt == EC - 1) begin
          for (int w = 0; w < NW; w++) mem[m_blk][w] = int'(ONES);
          m_st = 0;
        end else m_cnt++;
        4: begin
          if (mem[m_blk][m_cnt] != int'(ONES)) m_dirty = 1;
          if (m_cnt == NW - 1) begin if (m_dirty) e5 = 1; m_st = 0; end
          else m_cnt++;
        end
        default: m_st = 0;
      endcase
    end
  end

  function automatic logic [7:0] m_sr();
    bit rdy;
    rdy = !(m_st == 3 || m_st == 4);
    return {rdy, 1'b0, e5, e4, e3, 1'b0, e1, (m_st == 3 && int'(addr) / NW == m_blk)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [WW-1:0] er;
    er = m_stat ? WW'(m_sr()) : WW'(mem[int'(addr) / NW][int'(addr) % NW]);
    chk(rdata === er, cur_req, 32'(rdata), 32'(er));
    chk(standby === (!ce && m_sr()[7]), "R11", 32'(standby), 32'(!ce && m_sr()[7]));
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_cmd(int a, logic [7:0] d);
    step();
    ce = 1; we = 1; addr = AW'(a); wdata = d;
    step();
    we = 0;
  endtask

  task automatic rd_chk(int a, logic [WW-1:0] exp, string req);
    addr = AW'(a);
    @(negedge clk);
    chk(rdata === exp, req, 32'(rdata), 32'(exp));
    #3;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; step();
    // R1 reset state: array mode, zero contents, standby with ce low
    cur_req = "R1";
    rd_chk(5, 16'h0000, "R1");
    chk(standby === 1'b1, "R1", 32'(standby), 1);
    // R12 writes with ce low ignored
    cur_req = "R12";
    step(); ce = 0; we = 1; addr = AW'(8); wdata = 8'h20; step(); we = 0;
    rd_chk(8, 16'h0000, "R12");
    // R3 unknown code ignored in idle
    cur_req = "R3";
    wr_cmd(0, 8'h12);
    rd_chk(0, 16'h0000, "R3");
    // R8 blank check on unerased block 1
    cur_req = "R8";
    wr_cmd(8, 8'hBC);
    rd_chk(3, 16'h0080, "R3");
    wr_cmd(9, 8'hCB);
    rd_chk(9, 16'h0000, "R8");
    step(NW + 1);
    rd_chk(9, 16'h00A0, "R8");
    // R10 clear keeps status mode
    cur_req = "R10";
    wr_cmd(0, 8'h50);
    rd_chk(0, 16'h0080, "R10");
    // R2/R4/R9/R11 erase block 2
    cur_req = "R2";
    wr_cmd(16, 8'h20);
    wr_cmd(18, 8'hD0);
    rd_chk(17, 16'h0001, "R4");
    rd_chk(2, 16'h0000, "R4");
    cur_req = "R9";
    wr_cmd(16, 8'hFF);
    wr_cmd(16, 8'h20);
    rd_chk(16, 16'h0001, "R9");
    cur_req = "R11";
    ce = 0;
    step(3);
    chk(standby === 1'b0, "R11", 32'(standby), 0);
    step(EC);
    chk(standby === 1'b1, "R11", 32'(standby), 1);
    cur_req = "R2";
    rd_chk(16, 16'h0080, "R2");
    wr_cmd(0, 8'hFF);
    rd_chk(19, ONES, "R2");
    rd_chk(23, ONES, "R2");
    rd_chk(15, 16'h0000, "R2");
    rd_chk(24, 16'h0000, "R2");
    // R8 blank check of erased block passes, array untouched
    cur_req = "R8";
    wr_cmd(20, 8'hBC);
    wr_cmd(21, 8'hCB);
    step(NW + 1);
    rd_chk(20, 16'h0080, "R8");
    wr_cmd(0, 8'hFF);
    rd_chk(22, ONES, "R8");
    // R5 supply invalid, and priority over lock
    cur_req = "R5";
    vpp = 0;
    wr_cmd(24, 8'h20); wr_cmd(25, 8'hD0);
    rd_chk(24, 16'h0088, "R5");
    wr_cmd(0, 8'h50);
    lock = 4'b1000;
    wr_cmd(24, 8'h20); wr_cmd(25, 8'hD0);
    rd_chk(24, 16'h0088, "R5");
    wr_cmd(0, 8'h50);
    // R6 locked block
    cur_req = "R6";
    vpp = 1;
    wr_cmd(24, 8'h20); wr_cmd(25, 8'hD0);
    rd_chk(24, 16'h0082, "R6");
    wr_cmd(0, 8'h50); wr_cmd(0, 8'hFF);
    rd_chk(26, 16'h0000, "R6");
    lock = '0;
    // R7 sequence errors
    cur_req = "R7";
    wr_cmd(0, 8'h20); wr_cmd(8, 8'hD0);
    rd_chk(0, 16'h00B0, "R7");
    wr_cmd(0, 8'h50);
    wr_cmd(0, 8'h20); wr_cmd(0, 8'h50);
    rd_chk(0, 16'h00B0, "R7");
    wr_cmd(0, 8'h50);
    wr_cmd(0, 8'hBC); wr_cmd(0, 8'hD0);
    rd_chk(0, 16'h00B0, "R7");
    wr_cmd(0, 8'h50); wr_cmd(0, 8'hFF);
    rd_chk(1, 16'h0000, "R7");
    // R9 writes during blank check ignored
    cur_req = "R9";
    wr_cmd(0, 8'hBC); wr_cmd(0, 8'hCB);
    wr_cmd(0, 8'h20);
    step(NW);
    rd_chk(0, 16'h00A0, "R9");
    wr_cmd(0, 8'hD0);
    step(EC / 2);
    rd_chk(0, 16'h00A0, "R9");
    wr_cmd(0, 8'hFF);
    rd_chk(3, 16'h0000, "R9");
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule